// File: doc/BRIEF.md
# Polled Serial Status Shift Register

This block presents a 16-bit status word to a host through two wires: a strobe that the host toggles and a serial data line that it reads. There is no select line. The block finds frame boundaries by counting strobes. Every frame is a fixed number of strobes, 16 by default. On the first strobe of a frame, the block takes a snapshot of the parallel status input. Each later strobe moves the next higher bit onto the data line.

The host reads the line before it issues each strobe. As a result, the first value it collects in a frame is whatever the previous frame's final strobe left on the line. The host rebuilds the word with that stale value in position 0.

A one-cycle control-write pulse returns the frame position to the start and drives the line high. This lets the host resynchronise after a partial read. The strobe is brought into the system clock domain through a configurable synchronizer, and the active strobe edge is a parameter.

Top module: `status_serializer`

## Requirements
- R1: During reset and after it is released, the data line is high and the frame position is the start of a frame.
- R2: The active (rising, by default) strobe edge at the start of a frame captures the status input, and the data line then carries status bit 0.
- R3: Each further active strobe edge in the same frame puts the next higher captured bit on the line, so the bits leave in order from least to most significant.
- R4: When the host samples before each of the 16 strobes of a frame, sample k (k ≥ 1) equals captured bit k−1. Sample 0 is the value left over from before the frame: 1 after reset or a control write, otherwise the previous frame's bit 15.
- R5: After the 16th strobe, the line holds captured bit 15 until the next strobe. The frame counter then wraps, and that next strobe captures a fresh status value.
- R6: Changes on the status input after the first strobe of a frame do not affect the bits shifted in that frame.
- R7: A control-write pulse, even in the middle of a frame, drives the line high and returns to the start of a frame. The next strobe captures a new status value.
- R8: A strobe held active for many clock cycles advances the frame by exactly one bit.
- R9: Without an active strobe edge or a control write, the data line does not change, even when the status input does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Host serial clock, may be asynchronous to clk |
| status_in | input | 16 | Parallel status word to be read out |
| ctrl_wr | input | 1 | One-cycle pulse: control register written, frame restarts |
| sdo | output | 1 | Serial data line, idles high |

## Verification
The hardest condition to reach from the ports is a control write landing part-way through a frame. In that case the strobe count and the host's notion of the frame disagree, and the stale-first-bit rule must restart from the idle level rather than from a previous bit 15. The bench issues five strobes and then pulses the control write. It checks that the line is high, then reads a full frame and expects the leading sample to be 1. A second hard case is a status change after capture. The bench rewrites the status input between strobes of a running frame and expects the old snapshot to be shifted out.

// File: rtl/ss_pkg.sv
package ss_pkg;
   typedef enum logic {
      SS_EDGE_RISE = 1'b0,
      SS_EDGE_FALL = 1'b1
   } ss_edge_e;
endpackage

// File: rtl/ss_strobe_sync.sv
module ss_strobe_sync
   import ss_pkg::*;
#(
   parameter int       STAGES = 2,
   parameter ss_edge_e EDGE   = SS_EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   output logic step_o
);
   localparam logic IDLE = (EDGE == SS_EDGE_FALL);

   initial assert (STAGES >= 0 && STAGES <= 4)
      else $error("ss_strobe_sync: STAGES must lie in 0..4");

   logic synced;
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_raw
         assign synced = strobe_i;
      end else begin : g_sync
         logic [STAGES-1:0] chain_q;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk) begin
                  if (!rst_n) chain_q[0] <= IDLE;
                  else        chain_q[0] <= strobe_i;
               end
            end else begin : g_next
               always_ff @(posedge clk) begin
                  if (!rst_n) chain_q[i] <= IDLE;
                  else        chain_q[i] <= chain_q[i-1];
               end
            end
         end
         assign synced = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= IDLE;
      else        prev_q <= synced;
   end

   generate
      if (EDGE == SS_EDGE_RISE) begin : g_rise
         assign step_o = synced & ~prev_q;
      end else begin : g_fall
         assign step_o = ~synced & prev_q;
      end
   endgenerate

   // R8
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |=> !step_o);
endmodule

// File: rtl/ss_frame_ctr.sv
module ss_frame_ctr #(
   parameter int FRAME_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_i,
   input  logic clear_i,
   output logic load_o
);
   localparam int CW = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
   localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

   initial assert (FRAME_LEN >= 2)
      else $error("ss_frame_ctr: FRAME_LEN must be at least 2");

   logic [CW-1:0] pos_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         pos_q <= '0;
      end else if (step_i) begin
         if (pos_q == LAST) pos_q <= '0;
         else               pos_q <= pos_q + 1'b1;
      end
   end

   assign load_o = step_i & ~clear_i & (pos_q == '0);

   // R5
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !clear_i && pos_q == LAST) |=> (pos_q == '0));
   // R7
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (pos_q == '0));
endmodule

// File: rtl/ss_shifter.sv
module ss_shifter #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             load_i,
   input  logic             clear_i,
   input  logic [WIDTH-1:0] par_i,
   output logic             ser_o
);
   logic [WIDTH-1:0] sr_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) sr_q <= '1;
      else if (load_i)       sr_q <= par_i;
      else if (step_i)       sr_q <= {1'b1, sr_q[WIDTH-1:1]};
   end

   assign ser_o = sr_q[0];

   // R2
   load_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !clear_i) |=> (ser_o == $past(par_i[0])));
   // R7
   clear_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> ser_o);
   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !load_i && !clear_i) |=> $stable(ser_o));
endmodule

// File: rtl/status_serializer.sv
module status_serializer
   import ss_pkg::*;
#(
   parameter int       WIDTH       = 16,
   parameter int       SYNC_STAGES = 2,
   parameter ss_edge_e STROBE_EDGE = SS_EDGE_RISE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic [WIDTH-1:0] status_in,
   input  logic             ctrl_wr,
   output logic             sdo
);
   initial assert (WIDTH >= 2 && WIDTH <= 64)
      else $error("status_serializer: WIDTH must lie in 2..64");

   logic step;
   logic load;

   ss_strobe_sync #(.STAGES(SYNC_STAGES), .EDGE(STROBE_EDGE)) u_sync (
      .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .step_o(step));

   ss_frame_ctr #(.FRAME_LEN(WIDTH)) u_ctr (
      .clk(clk), .rst_n(rst_n), .step_i(step), .clear_i(ctrl_wr),
      .load_o(load));

   ss_shifter #(.WIDTH(WIDTH)) u_sh (
      .clk(clk), .rst_n(rst_n), .step_i(step), .load_i(load),
      .clear_i(ctrl_wr), .par_i(status_in), .ser_o(sdo));

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> sdo);
endmodule

// File: tb/status_serializer_test.sv
module status_serializer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strobe = 1'b0;
   logic [15:0] status_in = 16'h0000;
   logic        ctrl_wr = 1'b0;
   logic        sdo;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   status_serializer uut (
      .clk(clk), .rst_n(rst_n), .strobe(strobe),
      .status_in(status_in), .ctrl_wr(ctrl_wr), .sdo(sdo));

   localparam int NV = 6;
   localparam logic [15:0] VEC [0:NV-1] = '{
      16'h1234, 16'hFFFF, 16'h0000, 16'h8001, 16'h7FFE, 16'hA5C3 };

   task automatic check(input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic pulse();
      strobe = 1'b1;
      repeat (4) @(negedge clk);
      strobe = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic read_bits(input int n, inout logic [15:0] got, input int base);
      for (int i = 0; i < n; i++) begin
         got[base+i] = sdo;
         pulse();
      end
   endtask

   task automatic ctrl_pulse();
      ctrl_wr = 1'b1;
      @(negedge clk);
      ctrl_wr = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      logic [15:0] got;
      logic        stale;
      repeat (3) @(negedge clk);
      // R1: line high while in reset
      check("R1", {15'd0, sdo}, 16'd1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", {15'd0, sdo}, 16'd1);

      // R2 R3 R4 R5: table of frames, stale first sample
      stale = 1'b1;
      for (int v = 0; v < NV; v++) begin
         status_in = VEC[v];
         got = '0;
         read_bits(16, got, 0);
         check("R4", got, {VEC[v][14:0], stale});
         // R5: line holds bit 15 after the last strobe
         check("R5", {15'd0, sdo}, {15'd0, VEC[v][15]});
         stale = VEC[v][15];
      end

      // R2: first strobe puts bit 0 on the line
      status_in = 16'h0002;
      pulse();
      check("R2", {15'd0, sdo}, 16'd0);
      // R3: second strobe gives bit 1
      pulse();
      check("R3", {15'd0, sdo}, 16'd1);
      ctrl_pulse();

      // R6: status change mid-frame ignored
      status_in = 16'hC3A5;
      got = '0;
      read_bits(3, got, 0);
      status_in = 16'h0F0F;
      read_bits(13, got, 3);
      check("R6", got, {16'hC3A5 & 16'h7FFF} << 1 | 16'h0001);

      // R7: control write in mid frame
      status_in = 16'h5555;
      for (int i = 0; i < 5; i++) pulse();
      ctrl_pulse();
      check("R7", {15'd0, sdo}, 16'd1);
      status_in = 16'h3C96;
      got = '0;
      read_bits(16, got, 0);
      check("R7", got, {16'h3C96 & 16'h7FFF} << 1 | 16'h0001);
      ctrl_pulse();

      // R8: held strobe steps once
      status_in = 16'hFFFE;
      strobe = 1'b1;
      repeat (20) @(negedge clk);
      check("R8", {15'd0, sdo}, 16'd0);
      strobe = 1'b0;
      repeat (4) @(negedge clk);
      pulse();
      check("R8", {15'd0, sdo}, 16'd1);
      ctrl_pulse();

      // R9: no strobe, status wiggles, line stays
      status_in = 16'h0000;
      pulse();
      for (int i = 0; i < 10; i++) begin
         status_in = 16'(i * 16'h1111);
         @(negedge clk);
      end
      check("R9", {15'd0, sdo}, 16'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule